// File: doc/BRIEF.md
# Fine-Adjustable Precision Time Counter

This block keeps a precision time of day as a 32-bit seconds count and a 31-bit binary-fraction subsecond count, so that one full subsecond wrap is exactly one second. The time does not advance by a fixed amount each cycle. A 32-bit phase accumulator adds a programmable rate word on every reference clock edge, and only a carry out of that accumulator advances the subsecond count, by a programmable 8-bit step. A rate word near 2^31 runs the time at about half the reference rate. Moving the rate word trims the clock by less than one part per billion per code, over a range of about plus or minus 50 percent.

Software controls the block through a small word-wide register port. Two control bits act as one-shot commands that clear themselves in hardware. One moves a staged rate word into the active accumulator. The other loads a staged seconds and subseconds pair into the live counters. Software can poll both bits to confirm that the command has completed. The live seconds and subseconds can be read at any time. A frame-receive pulse latches the time into a two-word capture output. A capture of all zeros means no timestamp was taken, and a capture of all ones means the timestamp is corrupt.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, every register reads zero. This covers the counters, the accumulator, the active rate word, the control bits and the capture outputs, and `cap_valid` is low.
- R2: The register addresses are as follows.
  - 0 is control: bit0 run, bit1 fine mode, bit2 load command, bit3 rate command, bit4 snapshot enable.
  - 1 is the step, 8 bits.
  - 2 is the staged rate word, 32 bits.
  - 3 is the staged seconds.
  - 4 is the staged subseconds, 31 bits.
  - 5 is the live seconds, read only.
  - 6 is the live subseconds, read only.
  
  Writable fields read back as written, and unused bits read as zero. Writes to addresses 5 to 7 have no effect.
- R3: While run and fine mode are both set, each clock edge adds the active rate word to the accumulator modulo 2^32. The subseconds advance by the step only on an edge that produces a carry. From an accumulator of zero, a rate word of 0x80000000 carries on every second edge.
- R4: When the subseconds reach 2^31 or more, they wrap modulo 2^31, and the seconds increase by one on the same edge. The seconds wrap modulo 2^32.
- R5: While run or fine mode is clear, the accumulator, the seconds and the subseconds hold their values, except when a load command is pending.
- R6: A write to the staged rate word does not change the counting rate. Writing 1 to control bit3 copies the staged rate word into the active accumulator on the next edge. Bit3 reads 1 for exactly that one cycle and then reads 0.
- R7: Writing 1 to control bit2 loads the staged seconds and subseconds into the live counters on the next edge. Bit2 reads 1 for exactly that one cycle. The load overrides any advance on that edge and leaves the accumulator running.
- R8: On an edge where `rx_stamp` is high, `rx_ts_bad` is low and snapshot is enabled, `cap_sec` takes the seconds and `cap_sub` takes {1'b0, subseconds}, both as they were before that edge. `cap_valid` is high for the one cycle after each `rx_stamp` edge.
- R9: A frame event while snapshot is disabled writes zero to both capture words.
- R10: A frame event with `rx_ts_bad` high writes all ones to both capture words, whether or not snapshot is enabled.
- R11: A frame event on the same edge as a pending load captures the time from before the load.
- R12: The live seconds and subseconds are read without delay. A read of seconds, then subseconds, then seconds again across a subsecond wrap returns two different seconds values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| rx_stamp | input | 1 | Frame-receive event, one cycle |
| rx_ts_bad | input | 1 | Marks the event's timestamp as corrupt |
| cap_valid | output | 1 | Capture words were updated on the last edge |
| cap_sec | output | 32 | Captured seconds word |
| cap_sub | output | 32 | Captured subseconds word |

## Verification
A frame snapshot can land on the same edge as a load of new time. The bench provokes this by issuing the load command and raising `rx_stamp` on the very next edge. It then requires the capture to equal the seconds and subseconds read just before that edge, while the live counters show the staged values. A second collision, between a load and an accumulator carry that would otherwise advance the time, arises many times in the random phase. A cycle model in the bench judges each of these cycles on every register and every capture word.

// File: rtl/ptp_tc_pkg.sv
`timescale 1ns/1ps
package ptp_tc_pkg;

   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_STEP    = 3'd1,
      RA_RATE    = 3'd2,
      RA_LD_SEC  = 3'd3,
      RA_LD_SUB  = 3'd4,
      RA_NOW_SEC = 3'd5,
      RA_NOW_SUB = 3'd6,
      RA_SPARE   = 3'd7
   } reg_addr_e;

   // control word, bit0 = run ... bit4 = snapshot enable
   typedef struct packed {
      logic snap;
      logic rate_cmd;
      logic load_cmd;
      logic fine;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptp_tc_regs.sv
`timescale 1ns/1ps
module ptp_tc_regs
   import ptp_tc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned SUB_W  = 31,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned INC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   input  logic [SEC_W-1:0]  now_sec,
   input  logic [SUB_W-1:0]  now_sub,
   output ctrl_t             ctrl,
   output logic [INC_W-1:0]  step,
   output logic [ACC_W-1:0]  rate_stage,
   output logic [SEC_W-1:0]  ld_sec,
   output logic [SUB_W-1:0]  ld_sub,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl       <= '0;
         step       <= '0;
         rate_stage <= '0;
         ld_sec     <= '0;
         ld_sub     <= '0;
      end else begin
         // command bits last one cycle unless written again
         ctrl.load_cmd <= 1'b0;
         ctrl.rate_cmd <= 1'b0;
         if (wr_en) begin
            case (reg_addr_e'(wr_addr))
               RA_CTRL:   ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
               RA_STEP:   step       <= wr_data[INC_W-1:0];
               RA_RATE:   rate_stage <= wr_data[ACC_W-1:0];
               RA_LD_SEC: ld_sec     <= wr_data[SEC_W-1:0];
               RA_LD_SUB: ld_sub     <= wr_data[SUB_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_addr_e'(rd_addr))
         RA_CTRL:    rd_data[CTRL_W-1:0] = ctrl;
         RA_STEP:    rd_data[INC_W-1:0]  = step;
         RA_RATE:    rd_data[ACC_W-1:0]  = rate_stage;
         RA_LD_SEC:  rd_data[SEC_W-1:0]  = ld_sec;
         RA_LD_SUB:  rd_data[SUB_W-1:0]  = ld_sub;
         RA_NOW_SEC: rd_data[SEC_W-1:0]  = now_sec;
         RA_NOW_SUB: rd_data[SUB_W-1:0]  = now_sub;
         default:    rd_data             = '0;
      endcase
   end

endmodule

// File: rtl/ptp_tc_rate.sv
`timescale 1ns/1ps
module ptp_tc_rate #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rate_cmd,
   input  logic [ACC_W-1:0] rate_stage,
   output logic [ACC_W-1:0] rate_active,
   output logic             carry
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   acc_sum;

   assign acc_sum = {1'b0, acc_q} + {1'b0, rate_active};
   assign carry   = run & acc_sum[ACC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q       <= '0;
         rate_active <= '0;
      end else begin
         if (rate_cmd) rate_active <= rate_stage;
         if (run)      acc_q       <= acc_sum[ACC_W-1:0];
      end
   end

endmodule

// File: rtl/ptp_tc_time.sv
`timescale 1ns/1ps
module ptp_tc_time #(
   parameter int unsigned SEC_W = 32,
   parameter int unsigned SUB_W = 31,
   parameter int unsigned INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [INC_W-1:0] step,
   input  logic             load,
   input  logic [SEC_W-1:0] ld_sec,
   input  logic [SUB_W-1:0] ld_sub,
   output logic [SEC_W-1:0] now_sec,
   output logic [SUB_W-1:0] now_sub
);

   localparam int unsigned PAD_W = SUB_W + 1 - INC_W;

   logic [SUB_W:0] sub_sum;
   logic           sub_wrap;

   assign sub_sum  = {1'b0, now_sub} + {{PAD_W{1'b0}}, step};
   assign sub_wrap = sub_sum[SUB_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_sec <= '0;
         now_sub <= '0;
      end else if (load) begin
         now_sec <= ld_sec;
         now_sub <= ld_sub;
      end else if (advance) begin
         now_sub <= sub_sum[SUB_W-1:0];
         if (sub_wrap) now_sec <= now_sec + 1'b1;
      end
   end

endmodule

// File: rtl/ptp_tc_capture.sv
`timescale 1ns/1ps
module ptp_tc_capture #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SEC_W     = 32,
   parameter int unsigned SUB_W     = 31,
   parameter bit          MSB_ALIGN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stamp,
   input  logic              rx_ts_bad,
   input  logic              snap_en,
   input  logic [SEC_W-1:0]  now_sec,
   input  logic [SUB_W-1:0]  now_sub,
   output logic              cap_valid,
   output logic [SEC_W-1:0]  cap_sec,
   output logic [DATA_W-1:0] cap_sub
);

   localparam int unsigned FILL_W = DATA_W - SUB_W;

   logic [DATA_W-1:0] sub_word;

   generate
      if (MSB_ALIGN) begin : g_left
         assign sub_word = {now_sub, {FILL_W{1'b0}}};
      end else begin : g_right
         assign sub_word = {{FILL_W{1'b0}}, now_sub};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_sec   <= '0;
         cap_sub   <= '0;
      end else begin
         cap_valid <= rx_stamp;
         if (rx_stamp) begin
            if (rx_ts_bad) begin
               cap_sec <= '1;
               cap_sub <= '1;
            end else if (snap_en) begin
               cap_sec <= now_sec;
               cap_sub <= sub_word;
            end else begin
               cap_sec <= '0;
               cap_sub <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/ptp_time_counter.sv
`timescale 1ns/1ps
module ptp_time_counter
   import ptp_tc_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SEC_W         = 32,
   parameter int unsigned SUB_W         = 31,
   parameter int unsigned ACC_W         = 32,
   parameter int unsigned INC_W         = 8,
   parameter bit          CAP_MSB_ALIGN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rx_stamp,
   input  logic              rx_ts_bad,
   output logic              cap_valid,
   output logic [SEC_W-1:0]  cap_sec,
   output logic [DATA_W-1:0] cap_sub
);

   generate
      if (SUB_W >= DATA_W) begin : g_bad_sub
         $error("SUB_W must be narrower than DATA_W");
      end
      if (SEC_W > DATA_W || ACC_W > DATA_W) begin : g_bad_word
         $error("SEC_W and ACC_W must fit in DATA_W");
      end
      if (INC_W > SUB_W || INC_W == 0) begin : g_bad_step
         $error("INC_W must be between 1 and SUB_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_ctrl
         $error("DATA_W too narrow for control word");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [INC_W-1:0] step;
   logic [ACC_W-1:0] rate_stage;
   logic [ACC_W-1:0] rate_active;
   logic [SEC_W-1:0] ld_sec;
   logic [SUB_W-1:0] ld_sub;
   logic [SEC_W-1:0] now_sec;
   logic [SUB_W-1:0] now_sub;
   logic             carry;
   logic             run_fine;

   assign run_fine = ctrl.run & ctrl.fine;

   ptp_tc_regs #(
      .DATA_W (DATA_W), .SEC_W (SEC_W), .SUB_W (SUB_W),
      .ACC_W  (ACC_W),  .INC_W (INC_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .now_sec    (now_sec),
      .now_sub    (now_sub),
      .ctrl       (ctrl),
      .step       (step),
      .rate_stage (rate_stage),
      .ld_sec     (ld_sec),
      .ld_sub     (ld_sub),
      .rd_data    (rd_data)
   );

   ptp_tc_rate #(.ACC_W(ACC_W)) u_rate (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_fine),
      .rate_cmd    (ctrl.rate_cmd),
      .rate_stage  (rate_stage),
      .rate_active (rate_active),
      .carry       (carry)
   );

   ptp_tc_time #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (carry),
      .step    (step),
      .load    (ctrl.load_cmd),
      .ld_sec  (ld_sec),
      .ld_sub  (ld_sub),
      .now_sec (now_sec),
      .now_sub (now_sub)
   );

   ptp_tc_capture #(
      .DATA_W (DATA_W), .SEC_W (SEC_W), .SUB_W (SUB_W),
      .MSB_ALIGN (CAP_MSB_ALIGN)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_stamp  (rx_stamp),
      .rx_ts_bad (rx_ts_bad),
      .snap_en   (ctrl.snap),
      .now_sec   (now_sec),
      .now_sub   (now_sub),
      .cap_valid (cap_valid),
      .cap_sec   (cap_sec),
      .cap_sub   (cap_sub)
   );

endmodule

// File: rtl/ptp_tc_checker.sv
`timescale 1ns/1ps
module ptp_tc_checker
   import ptp_tc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned SUB_W  = 31,
   parameter int unsigned ACC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_wr,
   input logic              rx_stamp,
   input logic              rx_ts_bad,
   input logic              cap_valid,
   input logic [SEC_W-1:0]  cap_sec,
   input logic [DATA_W-1:0] cap_sub,
   input ctrl_t             ctrl,
   input logic [SEC_W-1:0]  ld_sec,
   input logic [SUB_W-1:0]  ld_sub,
   input logic [ACC_W-1:0]  rate_stage,
   input logic [ACC_W-1:0]  rate_active,
   input logic [SEC_W-1:0]  now_sec,
   input logic [SUB_W-1:0]  now_sub,
   input logic              carry
);

   assert_load_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.load_cmd && !load_wr |=> !ctrl.load_cmd);

   assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.load_cmd |=> (now_sec == $past(ld_sec)) && (now_sub == $past(ld_sub)));

   assert_rate_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.rate_cmd |=> rate_active == $past(rate_stage));

   assert_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.rate_cmd |=> $stable(rate_active));

   assert_time_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl.run && ctrl.fine) && !ctrl.load_cmd |=> $stable(now_sec) && $stable(now_sub));

   assert_no_carry_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !carry && !ctrl.load_cmd |=> $stable(now_sub) && $stable(now_sec));

   assert_sec_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.load_cmd |=> (now_sec == $past(now_sec)) || (now_sec == $past(now_sec) + 1'b1));

   assert_cap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stamp |=> cap_valid);

   assert_cap_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_stamp |=> !cap_valid);

   assert_cap_corrupt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stamp && rx_ts_bad |=> (&cap_sec) && (&cap_sub));

   assert_cap_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stamp && !rx_ts_bad && !ctrl.snap |=> (cap_sec == '0) && (cap_sub == '0));

   assert_cap_pre_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stamp && !rx_ts_bad && ctrl.snap |=> cap_sec == $past(now_sec));

endmodule

bind ptp_time_counter ptp_tc_checker #(
   .DATA_W (DATA_W), .SEC_W (SEC_W), .SUB_W (SUB_W), .ACC_W (ACC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_wr     (wr_en && (wr_addr == 3'd0) && wr_data[2]),
   .rx_stamp    (rx_stamp),
   .rx_ts_bad   (rx_ts_bad),
   .cap_valid   (cap_valid),
   .cap_sec     (cap_sec),
   .cap_sub     (cap_sub),
   .ctrl        (ctrl),
   .ld_sec      (ld_sec),
   .ld_sub      (ld_sub),
   .rate_stage  (rate_stage),
   .rate_active (rate_active),
   .now_sec     (now_sec),
   .now_sub     (now_sub),
   .carry       (carry)
);

// File: tb/test_ptp_time_counter.sv
`timescale 1ns/1ps
module test_ptp_time_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rx_stamp = 1'b0;
   logic        rx_ts_bad = 1'b0;
   logic        cap_valid;
   logic [31:0] cap_sec;
   logic [31:0] cap_sub;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ptp_time_counter i_ptp_time_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rx_stamp  (rx_stamp),
      .rx_ts_bad (rx_ts_bad),
      .cap_valid (cap_valid),
      .cap_sec   (cap_sec),
      .cap_sub   (cap_sub)
   );

   // ---------------- reference model (from the requirements) ----------------
   logic        m_run, m_fine, m_snap, m_load, m_rcmd;
   logic [7:0]  m_step;
   logic [31:0] m_stage, m_active, m_acc, m_ldsec, m_sec;
   logic [30:0] m_ldsub, m_sub;
   logic        m_cv;
   logic [31:0] m_csec, m_csub;
   logic [32:0] m_sum;
   logic [62:0] m_next;

   function automatic logic [62:0] add_step(input logic [31:0] s, input logic [30:0] f,
                                            input logic [7:0] inc);
      logic [31:0] t;
      t = {1'b0, f} + {24'd0, inc};
      if (t[31]) return {s + 32'd1, t[30:0]};
      return {s, t[30:0]};
   endfunction

   function automatic logic [31:0] ctrl_word();
      return {27'd0, m_snap, m_rcmd, m_load, m_fine, m_run};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_run, m_fine, m_snap, m_load, m_rcmd} <= '0;
         m_step <= '0; m_stage <= '0; m_active <= '0; m_acc <= '0;
         m_ldsec <= '0; m_sec <= '0; m_ldsub <= '0; m_sub <= '0;
         m_cv <= 1'b0; m_csec <= '0; m_csub <= '0;
      end else begin
         m_load <= wr_en && wr_addr == 3'd0 && wr_data[2];
         m_rcmd <= wr_en && wr_addr == 3'd0 && wr_data[3];
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_run <= wr_data[0]; m_fine <= wr_data[1]; m_snap <= wr_data[4]; end
               3'd1: m_step  <= wr_data[7:0];
               3'd2: m_stage <= wr_data;
               3'd3: m_ldsec <= wr_data;
               3'd4: m_ldsub <= wr_data[30:0];
               default: ;
            endcase
         end
         if (m_rcmd) m_active <= m_stage;
         m_sum = {1'b0, m_acc} + {1'b0, m_active};
         if (m_run && m_fine) m_acc <= m_sum[31:0];
         if (m_load) begin
            m_sec <= m_ldsec; m_sub <= m_ldsub;
         end else if (m_run && m_fine && m_sum[32]) begin
            m_next = add_step(m_sec, m_sub, m_step);
            m_sec <= m_next[62:31]; m_sub <= m_next[30:0];
         end
         m_cv <= rx_stamp;
         if (rx_stamp) begin
            if (rx_ts_bad)   begin m_csec <= '1;    m_csub <= '1; end
            else if (m_snap) begin m_csec <= m_sec; m_csub <= {1'b0, m_sub}; end
            else             begin m_csec <= '0;    m_csub <= '0; end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, s1, s2, pre_sec, pre_sub;
      void'($urandom(32'd20240917));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk($sformatf("R1 reg %0d", a), v, 32'd0);
      end
      chk("R1 cap_valid", {31'd0, cap_valid}, 32'd0);
      chk("R1 cap_sec", cap_sec, 32'd0);
      chk("R1 cap_sub", cap_sub, 32'd0);

      // R2 register readback and read-only addresses
      wr(3'd1, 32'hFFFF_FF04);
      rd(3'd1, v); chk("R2 step width", v, 32'h04);
      wr(3'd2, 32'h8000_0000);
      rd(3'd2, v); chk("R2 rate stage", v, 32'h8000_0000);
      wr(3'd3, 32'd7);
      rd(3'd3, v); chk("R2 load sec", v, 32'd7);
      wr(3'd4, 32'hFFFF_FFFC);
      rd(3'd4, v); chk("R2 load sub width", v, 32'h7FFF_FFFC);
      wr(3'd5, 32'h1234);
      rd(3'd5, v); chk("R2 write to live seconds ignored", v, 32'd0);

      // R6 staged rate has no effect before the command
      wr(3'd0, 32'h3);
      rd(3'd0, v); chk("R2 ctrl readback", v, 32'h3);
      repeat (4) tick();
      rd(3'd6, v); chk("R6 no advance before rate command", v, 32'd0);
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h8);
      rd(3'd0, v); chk("R6 rate command pending", v, 32'h8);
      tick();
      rd(3'd0, v); chk("R6 rate command self-clears", v, 32'h0);

      // R7 load
      wr(3'd0, 32'h4);
      rd(3'd0, v); chk("R7 load command pending", v, 32'h4);
      rd(3'd5, v); chk("R7 seconds before load", v, 32'd0);
      tick();
      rd(3'd0, v); chk("R7 load command self-clears", v, 32'h0);
      rd(3'd5, v); chk("R7 seconds loaded", v, 32'd7);
      rd(3'd6, v); chk("R7 subseconds loaded", v, 32'h7FFF_FFFC);

      // R5 hold while stopped or not in fine mode
      repeat (5) tick();
      rd(3'd6, v); chk("R5 hold with run clear", v, 32'h7FFF_FFFC);
      wr(3'd0, 32'h1);
      repeat (4) tick();
      rd(3'd6, v); chk("R5 hold with fine clear", v, 32'h7FFF_FFFC);

      // R3, R4, R12: carry every second edge, wrap, three-read pattern
      wr(3'd0, 32'h3);
      rd(3'd5, s1);
      tick();
      rd(3'd6, v); chk("R3 no carry on first edge", v, 32'h7FFF_FFFC);
      tick();
      rd(3'd5, s2); chk("R4 seconds carry on wrap", s2, 32'd8);
      rd(3'd6, v);  chk("R4 subseconds wrap", v, 32'd0);
      chk("R12 second read differs", {31'd0, s1 != s2}, 32'd1);
      tick();
      rd(3'd6, v); chk("R3 no step on odd edge", v, 32'd0);
      tick();
      rd(3'd6, v); chk("R3 step on carry", v, 32'd4);
      wr(3'd0, 32'h0);   // accumulator now at 0x80000000

      // R4 seconds wrap modulo 2^32
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'h7FFF_FFFE);
      wr(3'd0, 32'h4);
      tick();
      wr(3'd0, 32'h3);
      tick();
      rd(3'd5, v); chk("R4 seconds wrap to zero", v, 32'd0);
      rd(3'd6, v); chk("R4 subseconds after wrap", v, 32'd2);
      wr(3'd0, 32'h0);

      // R8 snapshot, R9 disabled snapshot, R10 corrupt
      wr(3'd0, 32'h10);
      rd(3'd5, pre_sec); rd(3'd6, pre_sub);
      rx_stamp = 1'b1; tick(); rx_stamp = 1'b0;
      chk("R8 cap_valid", {31'd0, cap_valid}, 32'd1);
      chk("R8 cap_sec", cap_sec, pre_sec);
      chk("R8 cap_sub", cap_sub, pre_sub);
      tick();
      chk("R8 cap_valid one cycle", {31'd0, cap_valid}, 32'd0);
      chk("R8 capture holds", cap_sec, pre_sec);
      rx_stamp = 1'b1; rx_ts_bad = 1'b1; tick(); rx_stamp = 1'b0; rx_ts_bad = 1'b0;
      chk("R10 corrupt sec", cap_sec, 32'hFFFF_FFFF);
      chk("R10 corrupt sub", cap_sub, 32'hFFFF_FFFF);
      wr(3'd0, 32'h0);
      rx_stamp = 1'b1; tick(); rx_stamp = 1'b0;
      chk("R9 no-stamp sec", cap_sec, 32'd0);
      chk("R9 no-stamp sub", cap_sub, 32'd0);

      // R11 snapshot on the same edge as a load
      wr(3'd3, 32'h55);
      wr(3'd4, 32'h1000);
      wr(3'd0, 32'h17);
      rd(3'd5, pre_sec); rd(3'd6, pre_sub);
      rx_stamp = 1'b1; tick(); rx_stamp = 1'b0;
      chk("R11 capture takes pre-load seconds", cap_sec, pre_sec);
      chk("R11 capture takes pre-load subseconds", cap_sub, pre_sub);
      rd(3'd5, v); chk("R11 live seconds loaded", v, 32'h55);
      rd(3'd6, v); chk("R11 live subseconds loaded", v, 32'h1000);

      // random phase, R3 R4 R5 R6 R7 R8 R9 R10 R11 against the model
      for (int i = 0; i < 4000; i++) begin
         tick();
         rd(3'd5, v); chk("R4 random seconds", v, m_sec);
         rd(3'd6, v); chk("R3 random subseconds", v, {1'b0, m_sub});
         rd(3'd0, v); chk("R7 random control", v, ctrl_word());
         chk("R8 random cap_valid", {31'd0, cap_valid}, {31'd0, m_cv});
         chk("R8 random cap_sec", cap_sec, m_csec);
         chk("R8 random cap_sub", cap_sub, m_csub);
         wr_en     = ($urandom % 3) == 0;
         wr_addr   = 3'($urandom % 8);
         case (wr_addr)
            3'd0: wr_data = {27'd0, 1'($urandom), 1'($urandom % 4 == 0),
                             1'($urandom % 3 == 0), 1'($urandom % 8 != 0), 1'($urandom % 8 != 0)};
            3'd2: wr_data = ($urandom % 2) ? (32'h8000_0000 + 32'($urandom % 4096) - 32'd2048)
                                           : $urandom;
            3'd3: wr_data = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
            3'd4: wr_data = 32'h7FFF_FF00 + 32'($urandom % 256);
            default: wr_data = $urandom;
         endcase
         rx_stamp  = ($urandom % 8) == 0;
         rx_ts_bad = ($urandom % 5) == 0;
      end
      wr_en = 1'b0; rx_stamp = 1'b0; rx_ts_bad = 1'b0;
      tick();

      summary();
      $finish;
   end

endmodule